// File: doc/BRIEF.md
# Interrupt Pending State Controller

This block tracks the pending state of a bank of interrupt lines. Each line is configured as either edge-triggered or level-sensitive. The block samples the raw input levels once per clock and keeps one software-visible pending latch per line. Software sets or clears pending bits by writing bit masks with a strobe. Software also writes whole words to configure the per-line enable and trigger-mode bits.

The pending value that software reads back is built from two parts: the latch and the sampled input level. The block keeps these two apart, so a level-sensitive line that software marked pending stays pending after its input drops. The enable bit only decides whether a pending line raises its forward request toward the CPU side. It never decides whether pending is recorded. A single "any request" output is the OR of all forward requests.

Top module: `irq_pend_ctrl`

## Requirements
- R1: On an edge-triggered line, a 0-to-1 change of the input between two clock samples sets the line's latch at that clock edge. This happens whether the line is enabled or not, and the pending readback shows it in the following cycle.
- R2: `fwd_req[i]` is high exactly when `pend_rdata[i]` and the line's enable bit are both 1. `any_req` is the OR of all `fwd_req` bits. Changing the enable bits never changes `pend_rdata`.
- R3: On an edge-triggered line, a 1-to-0 change of the input leaves the pending readback unchanged.
- R4: On a level-sensitive line, the pending readback is the latch ORed with the sampled input level. When the input falls, only the input's share of pending goes away, and a latch that software set stays set.
- R5: When `set_we` is high, each 1 bit of `set_mask` sets that line's latch. Bits at 0 have no effect.
- R6: When `clr_we` is high, each 1 bit of `clr_mask` clears that line's latch. Bits at 0 have no effect.
- R7: Same-cycle conflicts resolve as follows. A set and a clear of one line leave it pending. A clear and a hardware rising edge on an edge-triggered line leave it pending.
- R8: Mode bit 1 selects edge-triggered and mode bit 0 selects level-sensitive. `mode_we` loads `mode_wdata` and `en_we` loads `en_wdata`, and each takes effect from the next cycle.
- R9: Synchronous active-high reset clears all latches, sampled levels, enables and modes. After reset, `pend_rdata`, `fwd_req` and `any_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw interrupt input levels |
| set_we | input | 1 | Set-pending write strobe |
| set_mask | input | N_LINES | Lines to mark pending |
| clr_we | input | 1 | Clear-pending write strobe |
| clr_mask | input | N_LINES | Lines to clear |
| en_we | input | 1 | Enable word write strobe |
| en_wdata | input | N_LINES | New enable bits |
| mode_we | input | 1 | Trigger-mode word write strobe |
| mode_wdata | input | N_LINES | New mode bits (1 = edge) |
| pend_rdata | output | N_LINES | Pending readback view |
| fwd_req | output | N_LINES | Per-line forward request |
| any_req | output | 1 | OR of all forward requests |

## Verification
The bench drives rising and falling inputs on edge-triggered lines, both enabled and disabled. This separates edge capture from forwarding. It then pulses level-sensitive lines with and without a software latch already set. This shows whether the readback keeps the latch apart from the live level. Writes with empty masks, same-cycle set and clear, and clears that land together with a hardware edge expose each priority rule. A mode change while inputs are held high checks which mode the latch update and the readback use.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    typedef struct packed {
        logic set;
        logic clr;
    } sw_req_t;

    function automatic logic next_latch(
        input logic       cur,
        input sw_req_t    req,
        input trig_mode_e mode,
        input line_ev_t   ev
    );
        logic hw_set;
        hw_set = (mode == TRIG_EDGE) && ev.rise;
        return (cur && !req.clr) || req.set || hw_set;
    endfunction

    function automatic logic pend_view(
        input logic       latch,
        input trig_mode_e mode,
        input logic       level
    );
        return (mode == TRIG_LEVEL) ? (latch || level) : latch;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pend_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_we,
    input  logic [N_LINES-1:0]       en_wdata,
    input  logic                     mode_we,
    input  logic [N_LINES-1:0]       mode_wdata,
    output logic [N_LINES-1:0]       en_q,
    output trig_mode_e [N_LINES-1:0] mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= en_wdata;
        end
    end

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst) begin
                    mode_q[i] <= TRIG_LEVEL;
                end else if (mode_we) begin
                    mode_q[i] <= trig_mode_e'(mode_wdata[i]);
                end
            end
        end
    endgenerate

    // R8: a mode word write lands in the next cycle
    p_mode_load_r8: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (mode_q == $past(mode_wdata)));

    // R8: an enable word write lands in the next cycle
    p_en_load_r8: assert property (@(posedge clk) disable iff (rst)
        en_we |=> (en_q == $past(en_wdata)));

endmodule

// File: rtl/irq_input_sampler.sv
module irq_input_sampler
    import irq_pend_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N_LINES-1:0]     irq_in,
    output line_ev_t [N_LINES-1:0] ev
);

    logic [N_LINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= irq_in;
        end
    end

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_ev
            always_comb begin
                ev[i].level = prev_q[i];
                ev[i].rise  = irq_in[i] && !prev_q[i];
                ev[i].fall  = !irq_in[i] && prev_q[i];
            end
        end
    endgenerate

endmodule

// File: rtl/irq_pend_line.sv
module irq_pend_line
    import irq_pend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sw_req_t    req,
    input  trig_mode_e mode,
    input  line_ev_t   ev,
    output logic       latch_q,
    output logic       pend
);

    logic latch_d;

    always_comb begin
        latch_d = next_latch(latch_q, req, mode, ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
        end else begin
            latch_q <= latch_d;
        end
    end

    always_comb begin
        pend = pend_view(latch_q, mode, ev.level);
    end

    p_edge_capture_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && ev.rise) |=> latch_q);

    p_edge_fall_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_EDGE && ev.fall && !req.set && !req.clr) |=> $stable(latch_q));

    p_level_latch_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == TRIG_LEVEL && latch_q && !req.clr) |=> latch_q);

    p_sw_set_r5: assert property (@(posedge clk) disable iff (rst)
        req.set |=> latch_q);

    p_sw_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (req.clr && !req.set && !(mode == TRIG_EDGE && ev.rise)) |=> !latch_q);

    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (req.clr && req.set) |=> latch_q);

    p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (req.clr && mode == TRIG_EDGE && ev.rise) |=> latch_q);

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               set_we,
    input  logic [N_LINES-1:0] set_mask,
    input  logic               clr_we,
    input  logic [N_LINES-1:0] clr_mask,
    input  logic               en_we,
    input  logic [N_LINES-1:0] en_wdata,
    input  logic               mode_we,
    input  logic [N_LINES-1:0] mode_wdata,
    output logic [N_LINES-1:0] pend_rdata,
    output logic [N_LINES-1:0] fwd_req,
    output logic               any_req
);

    logic [N_LINES-1:0]       en_q;
    trig_mode_e [N_LINES-1:0] mode_q;
    line_ev_t [N_LINES-1:0]   ev;
    logic [N_LINES-1:0]       latch_q;

    irq_cfg_regs #(.N_LINES(N_LINES)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .en_q       (en_q),
        .mode_q     (mode_q)
    );

    irq_input_sampler #(.N_LINES(N_LINES)) u_samp (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .ev     (ev)
    );

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            sw_req_t req;
            always_comb begin
                req.set = set_we && set_mask[i];
                req.clr = clr_we && clr_mask[i];
            end

            irq_pend_line u_line (
                .clk     (clk),
                .rst     (rst),
                .req     (req),
                .mode    (mode_q[i]),
                .ev      (ev[i]),
                .latch_q (latch_q[i]),
                .pend    (pend_rdata[i])
            );
        end
    endgenerate

    always_comb begin
        fwd_req = pend_rdata & en_q;
        any_req = |fwd_req;
    end

    // R2: a disabled line never forwards
    p_disabled_silent_r2: assert property (@(posedge clk) disable iff (rst)
        ((fwd_req & ~en_q) == '0));

    // R2: the summary output agrees with the per-line requests
    p_any_matches_r2: assert property (@(posedge clk) disable iff (rst)
        (any_req == (fwd_req != '0)));

    // R1: enable state has no say in edge capture
    p_edge_ignores_enable_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_q[0] == TRIG_EDGE && ev[0].rise) |=> pend_rdata[0]);

endmodule

// File: tb/sim_irq_pend_ctrl.sv
module sim_irq_pend_ctrl;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] irq_in, set_mask, clr_mask, en_wdata, mode_wdata;
    logic         set_we, clr_we, en_we, mode_we;
    logic [N-1:0] pend_rdata, fwd_req;
    logic         any_req;

    irq_pend_ctrl #(.N_LINES(N)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .set_we(set_we), .set_mask(set_mask),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .en_we(en_we), .en_wdata(en_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pend_rdata(pend_rdata), .fwd_req(fwd_req), .any_req(any_req)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [N-1:0] pend;
        logic [N-1:0] fwd;
        logic         any;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    logic [N-1:0] m_lat, m_inq, m_en, m_mode;

    // Scoreboard monitor: one expected item per cycle, compared after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (pend_rdata !== e.pend || fwd_req !== e.fwd || any_req !== e.any) begin
                    errors++;
                    $display("FAIL %s: pend=%h fwd=%h any=%b expected pend=%h fwd=%h any=%b",
                             e.tag, pend_rdata, fwd_req, any_req, e.pend, e.fwd, e.any);
                end
            end
        end
    end

    task automatic step(
        input logic [N-1:0] irq,
        input logic sw, input logic [N-1:0] sm,
        input logic cw, input logic [N-1:0] cm,
        input logic ew, input logic [N-1:0] ed,
        input logic mw, input logic [N-1:0] md,
        input string tag
    );
        logic [N-1:0] rise, s, c, pend;
        exp_t e;
        @(negedge clk);
        irq_in = irq; set_we = sw; set_mask = sm; clr_we = cw; clr_mask = cm;
        en_we = ew; en_wdata = ed; mode_we = mw; mode_wdata = md;
        rise  = irq & ~m_inq;
        s     = sw ? sm : '0;
        c     = cw ? cm : '0;
        m_lat = (m_lat & ~c) | s | (rise & m_mode);
        m_inq = irq;
        if (ew) m_en = ed;
        if (mw) m_mode = md;
        pend  = m_lat | (m_inq & ~m_mode);
        e.pend = pend;
        e.fwd  = pend & m_en;
        e.any  = |(pend & m_en);
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        @(negedge clk);
        set_we = 0; clr_we = 0; en_we = 0; mode_we = 0;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        irq_in = '0; set_we = 0; set_mask = '0; clr_we = 0; clr_mask = '0;
        en_we = 0; en_wdata = '0; mode_we = 0; mode_wdata = '0;
        m_lat = '0; m_inq = '0; m_en = '0; m_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: state after reset, no stimulus
        step('0, 0, '0, 0, '0, 0, '0, 0, '0, "R9");
        // R8: lines 0-3 edge (mode 1), enable lines 0 and 2
        step('0, 0, '0, 0, '0, 1, 8'h05, 1, 8'h0F, "R8");
        // R1: rise on lines 0,1; line 1 disabled but still pending
        step(8'h03, 0, '0, 0, '0, 0, '0, 0, '0, "R1");
        // R3: falling edges keep pending
        step(8'h00, 0, '0, 0, '0, 0, '0, 0, '0, "R3");
        // R6: clear line 0
        step(8'h00, 0, '0, 1, 8'h01, 0, '0, 0, '0, "R6");
        // R6: clear strobe with all-zero mask has no effect
        step(8'h00, 0, '0, 1, 8'h00, 0, '0, 0, '0, "R6");
        // R5: set strobe with all-zero mask has no effect
        step(8'h00, 1, 8'h00, 0, '0, 0, '0, 0, '0, "R5");
        // R2: enable everything, line 1 now forwards
        step(8'h00, 0, '0, 0, '0, 1, 8'hFF, 0, '0, "R2");
        // R4: level line 4 high
        step(8'h10, 0, '0, 0, '0, 0, '0, 0, '0, "R4");
        // R4: level line 4 drops, no latch
        step(8'h00, 0, '0, 0, '0, 0, '0, 0, '0, "R4");
        // R5: software set on level line 5
        step(8'h00, 1, 8'h20, 0, '0, 0, '0, 0, '0, "R5");
        // R4: line 5 input pulses; software latch survives the fall
        step(8'h20, 0, '0, 0, '0, 0, '0, 0, '0, "R4");
        step(8'h00, 0, '0, 0, '0, 0, '0, 0, '0, "R4");
        // R7: set and clear of line 6 together
        step(8'h00, 1, 8'h40, 1, 8'h40, 0, '0, 0, '0, "R7");
        // R7: clear line 2 while its edge input rises
        step(8'h04, 0, '0, 1, 8'h04, 0, '0, 0, '0, "R7");
        // R5: set line 3 while it also rises
        step(8'h0C, 1, 8'h08, 0, '0, 0, '0, 0, '0, "R5");
        // R2: disable all, pending view unchanged
        step(8'h0C, 0, '0, 0, '0, 1, 8'h00, 0, '0, "R2");
        // R6: clear every latch; edge lines with high inputs drop
        step(8'h0C, 0, '0, 1, 8'hFF, 0, '0, 0, '0, "R6");
        // R8: switch to all level with inputs held high
        step(8'h0C, 0, '0, 0, '0, 1, 8'h0C, 1, 8'h00, "R8");
        // R4: inputs drop on now-level lines
        step(8'h00, 0, '0, 0, '0, 0, '0, 0, '0, "R4");
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule